// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns one 32-bit instruction word into the full set of control signals for a five-stage integer pipeline. One decoder drives every stage. It produces the three register indices and the immediate. It tells the execute stage which operands and which ALU function to use, and which branch compare to apply. It tells the memory stage whether to read or write a word. It tells the writeback stage whether to write and where the written value comes from: the ALU result, the memory output, or the link address (PC+4). Branch and jump targets are computed by the ALU as PC plus immediate. An upper-immediate load is handled by passing an already shifted immediate through the ALU.

The decoder registers its outputs, so the decode result for a word applied before a rising edge is visible right after that edge. A synchronous, active-high reset loads a bubble. Any opcode or function combination outside the supported set also decodes to a bubble. Such a bubble cannot change architectural state downstream.

Top module: `rvdec_top`

## Requirements
- R1: All outputs are registered: the decode of `instr` sampled at a rising edge appears after that edge. While `rst` is high at an edge, the outputs become a bubble: every output is zero.
- R2: `src_a_idx` = instr[19:15], `src_b_idx` = instr[24:20] and `dst_idx` = instr[11:7] for every instruction word, including unsupported ones.
- R3: The immediate follows the instruction's format and is sign-extended from instr[31]:
  - I: instr[31:20].
  - S: {instr[31:25], instr[11:7]}.
  - B: {instr[31], instr[7], instr[30:25], instr[11:8], 0}.
  - U: {instr[31:12], 12 zero bits}.
  - J: {instr[31], instr[19:12], instr[20], instr[30:21], 0}.
  - Register-register words and bubbles give 0.
- R4: Opcode 0110111 (LUI) gives the following controls, with the U immediate:
  - `rf_we`=1 and `wb_src`=0 (ALU).
  - `opa_src`=2 (zero) and `opb_src`=1 (immediate).
  - `alu_op`=4 (pass operand B).
- R5: Opcode 0010011 gives `rf_we`=1, `wb_src`=0, `opa_src`=0 (register), `opb_src`=1 and the I immediate. The ALU function depends on the word:
  - funct3 000 (ADDI): `alu_op`=0 (add).
  - funct3 101 with instr[31:25]=0100000 (SRAI): `alu_op`=2.
  - funct3 101 with instr[31:25]=0000000 (SRLI): `alu_op`=3.
  - Anything else with this opcode is a bubble.
- R6: Opcode 0110011 with funct3 000 gives `rf_we`=1, `wb_src`=0, `opa_src`=0, `opb_src`=0 (register) and immediate 0. instr[31:25]=0000000 gives `alu_op`=0 and 0100000 gives `alu_op`=1 (subtract). Anything else with this opcode is a bubble.
- R7: Opcode 1100011 with funct3 in {000,001,100,101,110,111} gives the following controls, with the B immediate:
  - `rf_we`=0, `mem_cmd`=0, `branch_en`=1, `jump_en`=0.
  - `opa_src`=1 (PC), `opb_src`=1, `alu_op`=0.
  - `cmp_kind` = funct3, so less-than is 100.
  - funct3 010 or 011 is a bubble.
- R8: Opcode 0000011 with funct3 010 (load word) gives `rf_we`=1, `wb_src`=1 (memory), `mem_cmd`=1, `opa_src`=0, `opb_src`=1, `alu_op`=0 and the I immediate.
- R9: Opcode 0100011 with funct3 010 (store word) gives `rf_we`=0, `mem_cmd`=2, `opa_src`=0, `opb_src`=1, `alu_op`=0 and the S immediate.
- R10: Opcode 1101111 (JAL) gives the following controls, with the J immediate:
  - `rf_we`=1 and `wb_src`=2 (PC+4).
  - `jump_en`=1 and `branch_en`=0.
  - `opa_src`=1, `opb_src`=1 and `alu_op`=0.
- R11: Any other word decodes to a bubble: all controls, `cmp_kind` and the immediate are zero, and only the register indices of R2 are carried.
- R12: `jump_en` and `branch_en` are never both 1. `rf_we` is 0 whenever `branch_en`=1 or `mem_cmd`=2. `wb_src` is 0 whenever `rf_we`=0. `cmp_kind` is 0 whenever `branch_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word to decode |
| src_a_idx | output | 5 | First source register index |
| src_b_idx | output | 5 | Second source register index |
| dst_idx | output | 5 | Destination register index |
| imm_val | output | XLEN | Sign-extended immediate |
| rf_we | output | 1 | Register file write enable |
| wb_src | output | 2 | Writeback source: 0 ALU, 1 memory, 2 PC+4 |
| mem_cmd | output | 2 | Memory command: 0 none, 1 load word, 2 store word |
| jump_en | output | 1 | Unconditional jump |
| branch_en | output | 1 | Conditional branch |
| opa_src | output | 2 | ALU operand A: 0 register, 1 PC, 2 zero |
| opb_src | output | 1 | ALU operand B: 0 register, 1 immediate |
| alu_op | output | 3 | 0 add, 1 sub, 2 arith shift right, 3 logical shift right, 4 pass B |
| cmp_kind | output | 3 | Branch compare kind (funct3 of the branch) |

## Verification
The bench first decodes a fixed eight-instruction sequence: an upper-immediate load, an add-immediate, an arithmetic shift, a subtract, a less-than branch, a word load, a word store and a jump. These words show that each instruction class reaches its own control pattern.

It then builds branch, jump, store and upper-immediate words from randomly chosen offsets. These separate a correct bit scatter of each immediate format from a wrong one, because the decoded offset must equal the chosen value.

Next it flips instr[30] on the shift and add words, and walks the branch funct3 over all eight codes. This separates arithmetic from logical shifts and add from subtract, and marks which compare codes count as valid.

Last it applies fully random words, which are mostly unsupported. These show that garbage decodes to a bubble while the register indices still pass through.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int ILEN = 32;
  localparam int RIDX = 5;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPREG  = 7'b0110011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2} wb_src_e;
  typedef enum logic [1:0] {MC_NONE = 2'd0, MC_LDW = 2'd1, MC_STW = 2'd2} mem_cmd_e;
  typedef enum logic [1:0] {OA_REG = 2'd0, OA_PC = 2'd1, OA_ZERO = 2'd2} opa_src_e;
  typedef enum logic [2:0] {
    AF_ADD = 3'd0, AF_SUB = 3'd1, AF_SRA = 3'd2, AF_SRL = 3'd3, AF_PASSB = 3'd4
  } alu_op_e;
  typedef enum logic [2:0] {
    IF_NONE = 3'd0, IF_I = 3'd1, IF_S = 3'd2, IF_B = 3'd3, IF_U = 3'd4, IF_J = 3'd5
  } imm_fmt_e;

  typedef struct packed {
    logic     we;
    wb_src_e  wb;
    mem_cmd_e mc;
    logic     jmp;
    logic     br;
    opa_src_e opa;
    logic     opb_imm;
    alu_op_e  fn;
    logic [2:0] cmp;
  } ctrl_t;

  localparam ctrl_t CTRL_BUBBLE = '{
    we: 1'b0, wb: WB_ALU, mc: MC_NONE, jmp: 1'b0, br: 1'b0,
    opa: OA_REG, opb_imm: 1'b0, fn: AF_ADD, cmp: 3'd0
  };

endpackage

// File: rtl/rvdec_class.sv
module rvdec_class
  import rvdec_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctrl_t      ctrl,
  output imm_fmt_e   fmt
);

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  logic f7_base, f7_alt, br_f3_ok;

  always_comb begin
    f7_base  = (funct7 == F7_BASE);
    f7_alt   = (funct7 == F7_ALT);
    br_f3_ok = (funct3[2:1] != 2'b01);
  end

  always_comb begin
    ctrl = CTRL_BUBBLE;
    fmt  = IF_NONE;
    unique case (opcode)
      OPC_LUI: begin
        ctrl.we      = 1'b1;
        ctrl.opa     = OA_ZERO;
        ctrl.opb_imm = 1'b1;
        ctrl.fn      = AF_PASSB;
        fmt          = IF_U;
      end
      OPC_OPIMM: begin
        if (funct3 == 3'b000) begin
          ctrl.we      = 1'b1;
          ctrl.opb_imm = 1'b1;
          ctrl.fn      = AF_ADD;
          fmt          = IF_I;
        end else if (funct3 == 3'b101 && (f7_base || f7_alt)) begin
          ctrl.we      = 1'b1;
          ctrl.opb_imm = 1'b1;
          ctrl.fn      = f7_alt ? AF_SRA : AF_SRL;
          fmt          = IF_I;
        end
      end
      OPC_OPREG: begin
        if (funct3 == 3'b000 && (f7_base || f7_alt)) begin
          ctrl.we = 1'b1;
          ctrl.fn = f7_alt ? AF_SUB : AF_ADD;
        end
      end
      OPC_BRANCH: begin
        if (br_f3_ok) begin
          ctrl.br      = 1'b1;
          ctrl.opa     = OA_PC;
          ctrl.opb_imm = 1'b1;
          ctrl.cmp     = funct3;
          fmt          = IF_B;
        end
      end
      OPC_LOAD: begin
        if (funct3 == 3'b010) begin
          ctrl.we      = 1'b1;
          ctrl.wb      = WB_MEM;
          ctrl.mc      = MC_LDW;
          ctrl.opb_imm = 1'b1;
          fmt          = IF_I;
        end
      end
      OPC_STORE: begin
        if (funct3 == 3'b010) begin
          ctrl.mc      = MC_STW;
          ctrl.opb_imm = 1'b1;
          fmt          = IF_S;
        end
      end
      OPC_JAL: begin
        ctrl.we      = 1'b1;
        ctrl.wb      = WB_LINK;
        ctrl.jmp     = 1'b1;
        ctrl.opa     = OA_PC;
        ctrl.opb_imm = 1'b1;
        fmt          = IF_J;
      end
      default: begin
        ctrl = CTRL_BUBBLE;
        fmt  = IF_NONE;
      end
    endcase
  end

endmodule

// File: rtl/rvdec_imm.sv
module rvdec_imm
  import rvdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:7] ibits,
  input  imm_fmt_e        fmt,
  output logic [XLEN-1:0] imm
);

  logic [ILEN-1:0] raw;
  logic            sgn;

  always_comb begin
    sgn = ibits[31];
    unique case (fmt)
      IF_I:    raw = {{20{sgn}}, ibits[31:20]};
      IF_S:    raw = {{20{sgn}}, ibits[31:25], ibits[11:7]};
      IF_B:    raw = {{19{sgn}}, sgn, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
      IF_U:    raw = {ibits[31:12], 12'b0};
      IF_J:    raw = {{11{sgn}}, sgn, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
      default: raw = '0;
    endcase
  end

  generate
    if (XLEN > ILEN) begin : g_wide
      assign imm = {{(XLEN-ILEN){raw[ILEN-1]}}, raw};
    end else begin : g_native
      assign imm = raw[XLEN-1:0];
    end
  endgenerate

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
  import rvdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr,
  output logic [4:0]      src_a_idx,
  output logic [4:0]      src_b_idx,
  output logic [4:0]      dst_idx,
  output logic [XLEN-1:0] imm_val,
  output logic            rf_we,
  output logic [1:0]      wb_src,
  output logic [1:0]      mem_cmd,
  output logic            jump_en,
  output logic            branch_en,
  output logic [1:0]      opa_src,
  output logic            opb_src,
  output logic [2:0]      alu_op,
  output logic [2:0]      cmp_kind
);

  ctrl_t           ctrl_d;
  imm_fmt_e        fmt_d;
  logic [XLEN-1:0] imm_d;

  rvdec_class u_class (
    .opcode (instr[6:0]),
    .funct3 (instr[14:12]),
    .funct7 (instr[31:25]),
    .ctrl   (ctrl_d),
    .fmt    (fmt_d)
  );

  rvdec_imm #(.XLEN(XLEN)) u_imm (
    .ibits (instr[ILEN-1:7]),
    .fmt   (fmt_d),
    .imm   (imm_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_a_idx <= '0;
      src_b_idx <= '0;
      dst_idx   <= '0;
      imm_val   <= '0;
      rf_we     <= 1'b0;
      wb_src    <= WB_ALU;
      mem_cmd   <= MC_NONE;
      jump_en   <= 1'b0;
      branch_en <= 1'b0;
      opa_src   <= OA_REG;
      opb_src   <= 1'b0;
      alu_op    <= AF_ADD;
      cmp_kind  <= '0;
    end else begin
      src_a_idx <= instr[19:15];
      src_b_idx <= instr[24:20];
      dst_idx   <= instr[11:7];
      imm_val   <= imm_d;
      rf_we     <= ctrl_d.we;
      wb_src    <= ctrl_d.wb;
      mem_cmd   <= ctrl_d.mc;
      jump_en   <= ctrl_d.jmp;
      branch_en <= ctrl_d.br;
      opa_src   <= ctrl_d.opa;
      opb_src   <= ctrl_d.opb_imm;
      alu_op    <= ctrl_d.fn;
      cmp_kind  <= ctrl_d.cmp;
    end
  end

endmodule

// File: rtl/rvdec_chk.sv
module rvdec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instr,
  input logic [4:0]      src_a_idx,
  input logic [4:0]      dst_idx,
  input logic [XLEN-1:0] imm_val,
  input logic            rf_we,
  input logic [1:0]      wb_src,
  input logic [1:0]      mem_cmd,
  input logic            jump_en,
  input logic            branch_en,
  input logic [2:0]      cmp_kind
);

  AST_RESET_BUBBLE: assert property (@(posedge clk) rst |=> !rf_we && mem_cmd == 2'd0 && !jump_en && !branch_en); // R1
  AST_DST_FIELD: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> dst_idx == $past(instr[11:7]) && src_a_idx == $past(instr[19:15])); // R2
  AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (rst) instr[6:0] == 7'b0110111 |=> imm_val[11:0] == 12'd0); // R3
  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst) instr[6:0] == 7'b1100011 |=> !rf_we && mem_cmd == 2'd0); // R7
  AST_LOAD_WB_MEM: assert property (@(posedge clk) disable iff (rst) mem_cmd == 2'd1 |-> rf_we && wb_src == 2'd1); // R8
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) mem_cmd == 2'd2 |-> !rf_we); // R9
  AST_JAL_LINK: assert property (@(posedge clk) disable iff (rst) instr[6:0] == 7'b1101111 |=> jump_en && rf_we && wb_src == 2'd2); // R10
  AST_JMP_BR_EXCL: assert property (@(posedge clk) disable iff (rst) !(jump_en && branch_en)); // R12
  AST_CMP_ONLY_BR: assert property (@(posedge clk) disable iff (rst) !branch_en |-> cmp_kind == 3'd0); // R12

endmodule

bind rvdec_top rvdec_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr     (instr),
  .src_a_idx (src_a_idx),
  .dst_idx   (dst_idx),
  .imm_val   (imm_val),
  .rf_we     (rf_we),
  .wb_src    (wb_src),
  .mem_cmd   (mem_cmd),
  .jump_en   (jump_en),
  .branch_en (branch_en),
  .cmp_kind  (cmp_kind)
);

// File: tb/sim_rvdec_top.sv
module sim_rvdec_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [4:0]  src_a_idx, src_b_idx, dst_idx;
  logic [31:0] imm_val;
  logic        rf_we, jump_en, branch_en, opb_src;
  logic [1:0]  wb_src, mem_cmd, opa_src;
  logic [2:0]  alu_op, cmp_kind;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rvdec_top #(.XLEN(32)) u0 (
    .clk(clk), .rst(rst), .instr(instr),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
    .imm_val(imm_val), .rf_we(rf_we), .wb_src(wb_src), .mem_cmd(mem_cmd),
    .jump_en(jump_en), .branch_en(branch_en), .opa_src(opa_src),
    .opb_src(opb_src), .alu_op(alu_op), .cmp_kind(cmp_kind)
  );

  // control vector layout: we, wb[2], mc[2], jmp, br, opa[2], opb, fn[3], cmp[3]
  function automatic logic [16:0] pack_ctrl(logic we, logic [1:0] wb, logic [1:0] mc,
      logic jmp, logic br, logic [1:0] opa, logic opb, logic [2:0] fn, logic [2:0] cmp);
    return {we, wb, mc, jmp, br, opa, opb, fn, cmp};
  endfunction

  task automatic model(input logic [31:0] w, output logic [16:0] ctl,
                       output logic [31:0] imm, output string tag);
    logic [6:0] op = w[6:0];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    int         simm;
    ctl = '0; imm = '0; tag = "R11";
    if (op == 7'h37) begin
      tag = "R4"; ctl = pack_ctrl(1, 0, 0, 0, 0, 2, 1, 4, 0);
      imm = w & 32'hFFFFF000;
    end else if (op == 7'h13 && f3 == 0) begin
      tag = "R5"; ctl = pack_ctrl(1, 0, 0, 0, 0, 0, 1, 0, 0);
      simm = int'($signed(w[31:20])); imm = simm;
    end else if (op == 7'h13 && f3 == 5 && (f7 == 7'h20 || f7 == 7'h00)) begin
      tag = "R5"; ctl = pack_ctrl(1, 0, 0, 0, 0, 0, 1, (f7 == 7'h20) ? 3'd2 : 3'd3, 0);
      simm = int'($signed(w[31:20])); imm = simm;
    end else if (op == 7'h33 && f3 == 0 && (f7 == 7'h20 || f7 == 7'h00)) begin
      tag = "R6"; ctl = pack_ctrl(1, 0, 0, 0, 0, 0, 0, (f7 == 7'h20) ? 3'd1 : 3'd0, 0);
    end else if (op == 7'h63 && f3 != 2 && f3 != 3) begin
      tag = "R7"; ctl = pack_ctrl(0, 0, 0, 0, 1, 1, 1, 0, f3);
      simm = int'($signed({w[31], w[7], w[30:25], w[11:8], 1'b0})); imm = simm;
    end else if (op == 7'h03 && f3 == 2) begin
      tag = "R8"; ctl = pack_ctrl(1, 1, 1, 0, 0, 0, 1, 0, 0);
      simm = int'($signed(w[31:20])); imm = simm;
    end else if (op == 7'h23 && f3 == 2) begin
      tag = "R9"; ctl = pack_ctrl(0, 0, 2, 0, 0, 0, 1, 0, 0);
      simm = int'($signed({w[31:25], w[11:7]})); imm = simm;
    end else if (op == 7'h6F) begin
      tag = "R10"; ctl = pack_ctrl(1, 2, 0, 1, 0, 1, 1, 0, 0);
      simm = int'($signed({w[31], w[19:12], w[20], w[30:21], 1'b0})); imm = simm;
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // apply a word, let one edge register it, compare at the following negedge
  task automatic run(input logic [31:0] w);
    logic [16:0] ctl; logic [31:0] imm; string tag;
    instr = w;
    @(negedge clk);
    model(w, ctl, imm, tag);
    check("R2", "src_a", 32'(src_a_idx), 32'(w[19:15]));
    check("R2", "src_b", 32'(src_b_idx), 32'(w[24:20]));
    check("R2", "dst",   32'(dst_idx),   32'(w[11:7]));
    check("R3", "imm",   imm_val, imm);
    check(tag, "ctrl",
          32'(pack_ctrl(rf_we, wb_src, mem_cmd, jump_en, branch_en, opa_src, opb_src, alu_op, cmp_kind)),
          32'(ctl));
    check("R12", "excl", 32'(!(jump_en && branch_en) &&
          !(rf_we && (branch_en || mem_cmd == 2'd2)) && (rf_we || wb_src == 0)), 32'd1);
  endtask

  function automatic logic [31:0] enc_b(logic [12:0] o, logic [4:0] a, logic [4:0] b, logic [2:0] f3);
    return {o[12], o[10:5], b, a, f3, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] o, logic [4:0] d);
    return {o[20], o[10:1], o[11], o[19:12], d, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] o, logic [4:0] a, logic [4:0] b);
    return {o[11:5], b, a, 3'b010, o[4:0], 7'b0100011};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    instr = 32'h0000_006F;
    repeat (3) @(negedge clk);
    // R1: reset gives an all-zero bubble even with a jump word applied
    check("R1", "reset ctrl", 32'({rf_we, wb_src, mem_cmd, jump_en, branch_en, opa_src, opb_src, alu_op, cmp_kind}), 32'd0);
    check("R1", "reset imm", imm_val, 32'd0);
    check("R1", "reset idx", 32'({src_a_idx, src_b_idx, dst_idx}), 32'd0);
    rst = 1'b0;

    // fixed sequence covering each instruction class
    run({20'd30, 5'd15, 7'b0110111});                                  // R4 upper imm
    check("R4", "lui imm", imm_val, 32'd30 << 12);
    run({12'd4, 5'd8, 3'b000, 5'd2, 7'b0010011});                      // R5 add imm
    run({7'b0100000, 5'd4, 5'd8, 3'b101, 5'd2, 7'b0010011});           // R5 srai
    check("R5", "srai fn", 32'(alu_op), 32'd2);
    run({7'b0100000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011});           // R6 sub
    check("R6", "sub fn", 32'(alu_op), 32'd1);
    run(enc_b(-13'sd12, 5'd12, 5'd10, 3'b100));                        // R7 blt
    check("R7", "blt imm", imm_val, -32'sd12);
    check("R7", "blt cmp", 32'(cmp_kind), 32'd4);
    run({12'd4, 5'd7, 3'b010, 5'd11, 7'b0000011});                     // R8 load
    run(enc_s(12'd8, 5'd7, 5'd11));                                    // R9 store
    check("R9", "sw mem", 32'(mem_cmd), 32'd2);
    run(enc_j(21'd30, 5'd15));                                         // R10 jal
    check("R10", "jal imm", imm_val, 32'd30);

    // R3: random offsets round-trip through every format
    for (int k = 0; k < 200; k++) begin
      logic [12:0] bo = 13'($urandom) & ~13'd1;
      logic [20:0] jo = 21'($urandom) & ~21'd1;
      logic [11:0] so = 12'($urandom);
      run(enc_b(bo, 5'($urandom), 5'($urandom), 3'b101));
      check("R3", "b roundtrip", imm_val, 32'(signed'(bo)));
      run(enc_j(jo, 5'($urandom)));
      check("R3", "j roundtrip", imm_val, 32'(signed'(jo)));
      run(enc_s(so, 5'($urandom), 5'($urandom)));
      check("R3", "s roundtrip", imm_val, 32'(signed'(so)));
    end

    // R5/R6: bit 30 selects the variant; R7: every branch funct3
    run({7'b0000000, 5'd7, 5'd1, 3'b101, 5'd3, 7'b0010011});
    check("R5", "srli fn", 32'(alu_op), 32'd3);
    run({7'b0000000, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011});
    check("R6", "add fn", 32'(alu_op), 32'd0);
    run({7'b0000001, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011});           // R11 mul-like bubble
    check("R11", "bad funct7 we", 32'(rf_we), 32'd0);
    for (int f = 0; f < 8; f++) run(enc_b(13'd64, 5'd1, 5'd2, 3'(f))); // R7

    // R11: random words, mostly unsupported
    for (int k = 0; k < 3000; k++) run($urandom);
    // random words forced onto supported opcodes
    for (int k = 0; k < 3000; k++) begin
      logic [6:0] ops [7] = '{7'h37, 7'h13, 7'h33, 7'h63, 7'h03, 7'h23, 7'h6F};
      run({$urandom} & 32'hFFFF_FF80 | 32'(ops[$urandom % 7]));
    end

    // R1: reset mid-stream returns to bubble
    instr = enc_j(21'd8, 5'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "re-reset", 32'({rf_we, jump_en, imm_val}), 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule